// File: doc/BRIEF.md
# ADC Start-of-Conversion Sequencing Timer

This block schedules conversions for a sampling ADC. It has a small bank of start-of-conversion slots. Each slot holds two settings: a select that picks one line of a trigger bus, and an acquisition count that sets how long the sample switch stays closed. When the chosen trigger line is seen high, the slot becomes pending. When the timer is idle, it launches the lowest-numbered pending slot. It raises the sample enable for the programmed window, then holds busy through a fixed conversion phase of 13 ADC clocks. It ends with a one-clock done strobe that carries the slot index.

The trigger bus is sampled as plain request lines. Every cycle in which a selected line is high counts as a request, and requests to a slot that is already pending are merged into that slot's one pending request. The configuration port is a plain write strobe. A write is accepted in every cycle and there is no back-pressure. A write changes only conversions that launch after it, because the acquisition count is captured into the timer at launch.

Top module: `adc_soc_seq`

## Requirements
- R1: With an acquisition field A of 6 or more, sample_o stays high for exactly A+1 consecutive clocks per conversion.
- R2: An acquisition field written below 6 is stored as 6, which gives a 7-clock window. After reset every slot holds 6.
- R3: After sample_o falls, busy_o stays high for exactly 13 more clocks (the conversion phase), with sample_o low.
- R4: done_o is high for exactly one clock, in the clock that follows the last conversion clock. busy_o is low in that clock, and done_slot_o gives the slot index.
- R5: Slot s responds only to trig_i bit number sel(s), the 5-bit select field of that slot. A high level on any other bit does not start that slot.
- R6: When the timer is idle, a trigger seen high in cycle t makes sample_o first high in cycle t+2.
- R7: A trigger that arrives while a conversion is running is held pending. Pending slots launch one at a time after the current done, lowest slot index first.
- R8: Several triggers to a slot that is already pending produce a single conversion of that slot.
- R9: A trigger to a slot in the same cycle that slot is launched is kept as a new pending request, and it produces a second conversion.
- R10: The acquisition value is captured at launch. A write to the running slot affects only its later conversions.
- R11: While rst_ni is low, sample_o, busy_o and done_o are low and all pending requests are dropped. Reset also sets every slot's select to 0 and its acquisition field to 6.
- R12: sample_o is high only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ADC clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trig_i | input | 2**SEL_W (32) | Trigger request lines; each high cycle is a request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_slot_i | input | clog2(NUM_SLOTS) (2) | Slot addressed by the write |
| cfg_sel_i | input | SEL_W (5) | Trigger line number for the slot |
| cfg_acq_i | input | ACQ_W (6) | Acquisition field (window = value+1 clocks, floor 6) |
| sample_o | output | 1 | Sample switch enable |
| busy_o | output | 1 | High from the first sample clock through the last conversion clock |
| done_o | output | 1 | One-clock completion strobe |
| done_slot_o | output | clog2(NUM_SLOTS) (2) | Index of the completed slot, valid with done_o |

## Verification
The pending latch can be set and cleared in the same cycle. This happens when a slot's trigger line is high in exactly the clock edge at which that slot is launched. The bench provokes this by holding a slot's trigger high for two consecutive cycles from idle, so the second request lands on the launch edge. It judges the result by counting done strobes for that slot: there must be two, whereas the same double request made while a conversion is running must merge into one. A second collision is a configuration write in the middle of a conversion. It is judged by the measured window length of the current and the next conversion.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adcseq_cfg_bank.sv
// Per-slot configuration registers; the acquisition floor is applied on write.
module adcseq_cfg_bank #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2,
  parameter int SEL_W     = 5,
  parameter int ACQ_W     = 6,
  parameter int MIN_ACQ   = 6
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [SLOT_W-1:0]                slot_i,
  input  logic [SEL_W-1:0]                 sel_i,
  input  logic [ACQ_W-1:0]                 acq_i,
  output logic [NUM_SLOTS-1:0][SEL_W-1:0]  sel_o,
  output logic [NUM_SLOTS-1:0][ACQ_W-1:0]  acq_o
);
  localparam logic [ACQ_W-1:0] ACQ_FLOOR = ACQ_W'(MIN_ACQ);

  logic [ACQ_W-1:0] acq_clamped;
  assign acq_clamped = (acq_i < ACQ_FLOOR) ? ACQ_FLOOR : acq_i;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        sel_o[g] <= '0;
        acq_o[g] <= ACQ_FLOOR;
      end else if (we_i && (slot_i == SLOT_W'(g))) begin
        sel_o[g] <= sel_i;
        acq_o[g] <= acq_clamped;
      end
    end

    AST_ACQ_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (acq_o[g] >= ACQ_FLOOR)); // R2
  end
endmodule

// File: rtl/adcseq_pending.sv
// Trigger selection, pending latches and lowest-index pick.
module adcseq_pending #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2,
  parameter int SEL_W     = 5,
  parameter int TRIG_W    = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [TRIG_W-1:0]                trig_i,
  input  logic [NUM_SLOTS-1:0][SEL_W-1:0]  sel_i,
  input  logic                             clr_en_i,
  input  logic [SLOT_W-1:0]                clr_slot_i,
  output logic                             any_o,
  output logic [SLOT_W-1:0]                pick_o
);
  logic [NUM_SLOTS-1:0] hit;
  logic [NUM_SLOTS-1:0] pend_q;
  logic [NUM_SLOTS-1:0] clr_mask;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_hit
    assign hit[g] = trig_i[sel_i[g]];
  end

  always_comb begin
    clr_mask = '0;
    if (clr_en_i) clr_mask[clr_slot_i] = 1'b1;
  end

  // A new request in the clear cycle survives: set wins over clear.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_mask) | hit;
  end

  always_comb begin
    any_o  = |pend_q;
    pick_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (pend_q[i]) pick_o = SLOT_W'(i);
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
    AST_PEND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[g] && !(clr_en_i && clr_slot_i == SLOT_W'(g))) |=> pend_q[g]); // R7
    AST_HIT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[g] |=> pend_q[g]); // R9
  end
endmodule

// File: rtl/adcseq_timer.sv
// Sample window and conversion phase sequencer.
module adcseq_timer
  import adcseq_pkg::*;
#(
  parameter int SLOT_W      = 2,
  parameter int ACQ_W       = 6,
  parameter int CONV_CYCLES = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_any_i,
  input  logic [SLOT_W-1:0] req_slot_i,
  input  logic [ACQ_W-1:0]  req_acq_i,
  output logic              launch_o,
  output logic              sample_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [SLOT_W-1:0] done_slot_o
);
  localparam int CONV_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam int CNT_W  = (ACQ_W > CONV_W) ? ACQ_W : CONV_W;

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;

  assign launch_o    = (state_q == ST_IDLE) && req_any_i;
  assign sample_o    = (state_q == ST_SAMPLE);
  assign busy_o      = (state_q == ST_SAMPLE) || (state_q == ST_CONV);
  assign done_o      = (state_q == ST_DONE);
  assign done_slot_o = slot_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_any_i) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= CNT_W'(req_acq_i);
            slot_q  <= req_slot_i;
          end
        end
        ST_SAMPLE: begin
          if (cnt_q == '0) begin
            state_q <= ST_CONV;
            cnt_q   <= CNT_W'(CONV_CYCLES - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_CONV: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Independent run-length counter of conversion-phase clocks.
  logic [CONV_W:0] conv_run_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                 conv_run_q <= '0;
    else if (busy_o && !sample_o) conv_run_q <= conv_run_q + 1'b1;
    else                         conv_run_q <= '0;
  end

  AST_SAMPLE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> busy_o); // R12
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R4
  AST_CONV_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_o) |-> busy_o); // R3
  AST_CONV_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (conv_run_q == (CONV_W+1)'(CONV_CYCLES))); // R3
endmodule

// File: rtl/adc_soc_seq.sv
module adc_soc_seq #(
  parameter int NUM_SLOTS   = 4,
  parameter int SEL_W       = 5,
  parameter int ACQ_W       = 6,
  parameter int MIN_ACQ     = 6,
  parameter int CONV_CYCLES = 13,
  localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int TRIG_W     = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic              cfg_we_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [ACQ_W-1:0]  cfg_acq_i,
  output logic              sample_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [SLOT_W-1:0] done_slot_o
);
  logic [NUM_SLOTS-1:0][SEL_W-1:0] slot_sel;
  logic [NUM_SLOTS-1:0][ACQ_W-1:0] slot_acq;
  logic                            req_any;
  logic [SLOT_W-1:0]               req_slot;
  logic                            launch;

  adcseq_cfg_bank #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .SEL_W(SEL_W),
    .ACQ_W(ACQ_W), .MIN_ACQ(MIN_ACQ)
  ) cfg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .slot_i(cfg_slot_i),
    .sel_i(cfg_sel_i), .acq_i(cfg_acq_i), .sel_o(slot_sel), .acq_o(slot_acq)
  );

  adcseq_pending #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .SEL_W(SEL_W), .TRIG_W(TRIG_W)
  ) pend_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .sel_i(slot_sel),
    .clr_en_i(launch), .clr_slot_i(req_slot), .any_o(req_any), .pick_o(req_slot)
  );

  adcseq_timer #(
    .SLOT_W(SLOT_W), .ACQ_W(ACQ_W), .CONV_CYCLES(CONV_CYCLES)
  ) tmr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_any_i(req_any), .req_slot_i(req_slot),
    .req_acq_i(slot_acq[req_slot]), .launch_o(launch), .sample_o(sample_o),
    .busy_o(busy_o), .done_o(done_o), .done_slot_o(done_slot_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> (!sample_o && !busy_o && !done_o)); // R11
endmodule

// File: tb/adc_soc_seq_tb_top.sv
module adc_soc_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] trig = '0;
  logic        we = 1'b0;
  logic [1:0]  wslot = '0;
  logic [4:0]  wsel = '0;
  logic [5:0]  wacq = '0;
  logic        sample, busy, done;
  logic [1:0]  dslot;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  int rec_slot[512];
  int rec_w[512];
  int rec_c[512];
  int rec_st[512];
  int nrec = 0;
  int cur_w = 0, cur_c = 0, cur_st = 0;
  bit prev_s = 1'b0;

  always #10 clk = ~clk;

  adc_soc_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .cfg_we_i(we),
    .cfg_slot_i(wslot), .cfg_sel_i(wsel), .cfg_acq_i(wacq),
    .sample_o(sample), .busy_o(busy), .done_o(done), .done_slot_o(dslot)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Port monitor: measures window, conversion length and start cycle.
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_s = 1'b0; cur_w = 0; cur_c = 0;
    end else begin
      if (sample && !prev_s) begin cur_st = cyc; cur_w = 0; cur_c = 0; end
      if (sample) cur_w++;
      if (busy && !sample) cur_c++;
      if (done) begin
        chk(!busy, "R4 busy low at done", int'(busy), 0);
        if (nrec < 512) begin
          rec_slot[nrec] = int'(dslot); rec_w[nrec] = cur_w;
          rec_c[nrec] = cur_c; rec_st[nrec] = cur_st;
        end
        nrec++;
      end
      prev_s = sample;
    end
  end

  task automatic wr(input int s, input int sel, input int acq);
    @(negedge clk);
    we = 1'b1; wslot = 2'(s); wsel = 5'(sel); wacq = 6'(acq);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] bits, output int t);
    @(negedge clk);
    t = cyc; trig = bits;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic wait_recs(input int n, input string req);
    int guard = 0;
    while (nrec < n && guard < 600) begin @(posedge clk); guard++; end
    chk(nrec >= n, req, nrec, n);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    int t, base, exp_w;
    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    chk(!sample && !busy && !done, "R11 reset outputs", int'({sample, busy, done}), 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R3 R4 R6: sweep every acquisition code on slot 0
    for (int a = 0; a < 64; a++) begin
      wr(0, 4, a);
      base = nrec;
      pulse(32'h1 << 4, t);
      wait_recs(base + 1, "R1 conversion completes");
      exp_w = (a < 6) ? 7 : a + 1;
      chk(rec_w[base] == exp_w, (a < 6) ? "R2 clamped window" : "R1 window length",
          rec_w[base], exp_w);
      chk(rec_c[base] == 13, "R3 conversion length", rec_c[base], 13);
      chk(rec_slot[base] == 0, "R4 done slot", rec_slot[base], 0);
      chk(rec_st[base] == t + 2, "R6 start latency", rec_st[base], t + 2);
      idle(1);
    end

    // R5: only the selected trigger line starts a slot
    for (int b = 0; b < 32; b++) begin
      wr(1, b, 6);
      wr(0, (b + 1) % 32, 6);
      wr(2, (b + 2) % 32, 6);
      wr(3, (b + 3) % 32, 6);
      base = nrec;
      pulse(32'h1 << ((b + 16) % 32), t);
      idle(40);
      chk(nrec == base && !busy, "R5 unselected line ignored", nrec - base, 0);
      pulse(32'h1 << b, t);
      wait_recs(base + 1, "R5 selected line");
      chk(rec_slot[base] == 1, "R5 slot on selected line", rec_slot[base], 1);
      idle(2);
    end

    // R7: pending requests served in ascending slot order
    for (int s = 0; s < 4; s++) wr(s, s, 0);
    base = nrec;
    pulse(32'h8, t);
    idle(4);
    pulse(32'h7, t);
    wait_recs(base + 4, "R7 all pending served");
    chk(rec_slot[base] == 3, "R7 order 0", rec_slot[base], 3);
    chk(rec_slot[base+1] == 0, "R7 order 1", rec_slot[base+1], 0);
    chk(rec_slot[base+2] == 1, "R7 order 2", rec_slot[base+2], 1);
    chk(rec_slot[base+3] == 2, "R7 order 3", rec_slot[base+3], 2);
    chk(rec_w[base+1] == 7, "R2 floor from write of 0", rec_w[base+1], 7);
    idle(2);

    // R8: repeated requests while busy merge into one
    base = nrec;
    pulse(32'h8, t);
    idle(3);
    pulse(32'h1, t); idle(1);
    pulse(32'h1, t); idle(1);
    pulse(32'h1, t);
    idle(80);
    chk(nrec - base == 2, "R8 merged request count", nrec - base, 2);
    chk(rec_slot[base+1] == 0, "R8 merged slot", rec_slot[base+1], 0);

    // R9: request landing on the launch edge yields a second conversion
    base = nrec;
    @(negedge clk); trig = 32'h1;
    @(negedge clk); trig = 32'h1;
    @(negedge clk); trig = '0;
    idle(80);
    chk(nrec - base == 2, "R9 launch-edge request kept", nrec - base, 2);

    // R10: acquisition captured at launch
    wr(0, 0, 6);
    base = nrec;
    pulse(32'h1, t);
    idle(4);
    wr(0, 0, 20);
    wait_recs(base + 1, "R10 first conversion");
    chk(rec_w[base] == 7, "R10 running window unchanged", rec_w[base], 7);
    idle(2);
    pulse(32'h1, t);
    wait_recs(base + 2, "R10 second conversion");
    chk(rec_w[base+1] == 21, "R10 new window applied", rec_w[base+1], 21);
    idle(2);

    // R11: reset mid-conversion drops pending work and restores defaults
    for (int s = 1; s < 4; s++) wr(s, s, 6);
    base = nrec;
    pulse(32'h1, t);
    idle(4);
    pulse(32'h6, t);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(!sample && !busy && !done, "R11 outputs cleared", int'({sample, busy, done}), 0);
    idle(2);
    rst_n = 1'b1;
    idle(100);
    chk(nrec == base, "R11 pending dropped", nrec - base, 0);
    pulse(32'h1, t);
    idle(200);
    chk(nrec - base == 4, "R11 default select 0 on all slots", nrec - base, 4);
    chk(rec_w[base] == 7, "R11 default acquisition", rec_w[base], 7);
    chk(rec_slot[base+3] == 3, "R11 last slot served", rec_slot[base+3], 3);

    summary();
  end
endmodule